// File: doc/BRIEF.md
# Round-Robin Write-Back Arbiter

This block joins a set of fixed-latency execution channels to a shared result bus that can accept only a limited number of write-backs per cycle. Each channel is a pipeline of fixed depth. It accepts one instruction tag and result every cycle and never stalls. A completed entry leaving a channel drops into a small FIFO that belongs to that channel, so a busy bus never holds a channel up.

Every cycle a round-robin scan visits the FIFOs, starting from a stored scan pointer. Each non-empty FIFO that it reaches while bus capacity remains gives up its oldest entry, and the scan moves on. The scan stops when the capacity is used up or when every FIFO has been visited once. The pointer then records where the scan stopped, and the next cycle begins there. The granted entries appear on the write-back slots in scan order, each with the index of the channel it came from.

Top module: `wb_rr_arbiter`

## Requirements
- R1: Channel i has latency L_i = BASE_LAT + i. When its FIFO is empty and the bus is idle, an entry captured on `iss_valid[i]` at a clock edge appears on write-back slot 0 during the cycle that follows the L_i-th edge after the capturing edge.
- R2: A channel accepts a new entry on every cycle regardless of bus load, and the entries of one channel are written back in the order in which they were issued.
- R3: If a completed entry reaches a FIFO that is full, and no entry leaves that FIFO in the same cycle, the entry is dropped and `buf_ovf[i]` is set and stays set until reset. With traffic the bus can absorb, every `buf_ovf` bit stays 0.
- R4: Each cycle the number of valid write-back slots equals the smaller of COMMIT_W and the number of non-empty FIFOs.
- R5: A FIFO gives up at most one entry per cycle, always its oldest, and only when it is non-empty. `wb_chan` of a slot carries the index of that FIFO.
- R6: Valid slots are packed from slot 0 upward in the order in which the scan granted them.
- R7: The scan visits FIFOs in ascending index order, starting at the pointer and wrapping from NUM_CH-1 to 0.
- R8: When the COMMIT_W-th grant of a cycle goes to FIFO b, the next cycle's scan starts at FIFO (b+1) mod NUM_CH.
- R9: When fewer than COMMIT_W grants are made in a cycle, the next cycle's scan starts at the same FIFO as this one.
- R10: Reset empties all channels and FIFOs, clears every `buf_ovf` bit, drives no valid write-back slot, and sets the scan pointer to FIFO 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | NUM_CH | Issue strobe per channel |
| iss_tag | input | NUM_CH*TAG_W | Instruction tag per channel, channel i at bits [i*TAG_W +: TAG_W] |
| iss_data | input | NUM_CH*DATA_W | Result value per channel, channel i at bits [i*DATA_W +: DATA_W] |
| wb_valid | output | COMMIT_W | Write-back slot valid |
| wb_chan | output | COMMIT_W*CH_W | Source channel of each slot |
| wb_tag | output | COMMIT_W*TAG_W | Tag of each slot |
| wb_data | output | COMMIT_W*DATA_W | Result of each slot |
| buf_ovf | output | NUM_CH | Sticky overflow flag per FIFO |

## Verification
A FIFO can receive a completed entry from its pipeline and give up its head to the bus in the same cycle, and this matters most when the FIFO is full. In that case the arriving entry must be kept and no overflow raised. The case is provoked by issuing on all four channels every cycle against a two-slot bus, which drives every FIFO to full while grants keep rotating. It is judged by a bench-side reference queue per channel that is compared every cycle with the slots, the tags and the overflow flags.

// File: rtl/wb_arb_pkg.sv
package wb_arb_pkg;
   // modular advance of a ring index
   function automatic int unsigned rr_wrap(input int unsigned base,
                                           input int unsigned off,
                                           input int unsigned n);
      return (base + off) % n;
   endfunction
endpackage

// File: rtl/wb_lat_pipe.sv
module wb_lat_pipe #(
   parameter int unsigned LAT = 1,
   parameter int unsigned W   = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_v,
   input  logic [W-1:0] in_d,
   output logic         out_v,
   output logic [W-1:0] out_d
);
   if (LAT < 1) begin : g_bad_lat
      $error("wb_lat_pipe: LAT must be at least 1");
   end

   logic [LAT-1:0]        v_q;
   logic [LAT-1:0][W-1:0] d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= '0;
      end else begin
         v_q[0] <= in_v;
         for (int s = 1; s < int'(LAT); s++) v_q[s] <= v_q[s-1];
      end
   end

   always_ff @(posedge clk) begin
      d_q[0] <= in_d;
      for (int s = 1; s < int'(LAT); s++) d_q[s] <= d_q[s-1];
   end

   assign out_v = v_q[LAT-1];
   assign out_d = d_q[LAT-1];
endmodule

// File: rtl/wb_fifo.sv
module wb_fifo #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         ovf
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("wb_fifo: DEPTH must be at least 1");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rd_q, wr_q;
   logic [CW-1:0] cnt_q;
   logic          ovf_q;
   logic          full, do_pop, do_push;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         if (do_pop)  rd_q <= (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
         if (do_push) wr_q <= (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
         cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
         if (push && full && !pop) ovf_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_q] <= din;
   end

   assign dout = mem[rd_q];
   assign ovf  = ovf_q;

   // R5: a grant never reaches an empty buffer
   assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   // R3: arrival at a full buffer with no departure raises the flag
   assert_ovf_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> ovf);
   // R3: flag is sticky
   assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
   // R3: occupancy never exceeds the depth
   assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/wb_rr_scan.sv
module wb_rr_scan
   import wb_arb_pkg::*;
#(
   parameter int unsigned N    = 4,
   parameter int unsigned C    = 2,
   parameter int unsigned CH_W = 2
) (
   input  logic [CH_W-1:0]         start,
   input  logic [N-1:0]            avail,
   output logic [N-1:0]            grant,
   output logic [C-1:0]            slot_v,
   output logic [C-1:0][CH_W-1:0]  slot_ch,
   output logic [CH_W-1:0]         next_start
);
   always_comb begin
      int unsigned used;
      int unsigned visits;
      int unsigned idx;
      logic        done;
      grant   = '0;
      slot_v  = '0;
      slot_ch = '0;
      used    = 0;
      visits  = N;
      done    = 1'b0;
      for (int unsigned k = 0; k < N; k++) begin
         idx = rr_wrap(int'(start), k, N);
         if (!done && avail[idx]) begin
            grant[idx]    = 1'b1;
            slot_v[used]  = 1'b1;
            slot_ch[used] = CH_W'(idx);
            used          = used + 1;
            if (used == C) begin
               done   = 1'b1;
               visits = k + 1;
            end
         end
      end
      next_start = CH_W'(rr_wrap(int'(start), visits, N));
   end
endmodule

// File: rtl/wb_rr_arbiter.sv
module wb_rr_arbiter #(
   parameter int unsigned NUM_CH    = 4,
   parameter int unsigned COMMIT_W  = 2,
   parameter int unsigned BUF_DEPTH = 4,
   parameter int unsigned BASE_LAT  = 1,
   parameter int unsigned TAG_W     = 6,
   parameter int unsigned DATA_W    = 16,
   localparam int unsigned CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_CH-1:0]            iss_valid,
   input  logic [NUM_CH*TAG_W-1:0]      iss_tag,
   input  logic [NUM_CH*DATA_W-1:0]     iss_data,
   output logic [COMMIT_W-1:0]          wb_valid,
   output logic [COMMIT_W*CH_W-1:0]     wb_chan,
   output logic [COMMIT_W*TAG_W-1:0]    wb_tag,
   output logic [COMMIT_W*DATA_W-1:0]   wb_data,
   output logic [NUM_CH-1:0]            buf_ovf
);
   localparam int unsigned EW = TAG_W + DATA_W;

   if (NUM_CH < 2)    begin : g_bad_ch    $error("wb_rr_arbiter: NUM_CH must be at least 2"); end
   if (COMMIT_W < 1)  begin : g_bad_cw    $error("wb_rr_arbiter: COMMIT_W must be at least 1"); end
   if (BASE_LAT < 1)  begin : g_bad_lat   $error("wb_rr_arbiter: BASE_LAT must be at least 1"); end

   logic [NUM_CH-1:0][EW-1:0]       head;
   logic [NUM_CH-1:0]               empty;
   logic [NUM_CH-1:0]               avail;
   logic [NUM_CH-1:0]               grant;
   logic [COMMIT_W-1:0]             slot_v;
   logic [COMMIT_W-1:0][CH_W-1:0]   slot_ch;
   logic [CH_W-1:0]                 ptr_q, ptr_d;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      logic          done_v;
      logic [EW-1:0] done_d;

      wb_lat_pipe #(.LAT(BASE_LAT + ch), .W(EW)) pipe_i (
         .clk   (clk),
         .rst_n (rst_n),
         .in_v  (iss_valid[ch]),
         .in_d  ({iss_tag[ch*TAG_W +: TAG_W], iss_data[ch*DATA_W +: DATA_W]}),
         .out_v (done_v),
         .out_d (done_d)
      );

      wb_fifo #(.DEPTH(BUF_DEPTH), .W(EW)) buf_i (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (done_v),
         .din   (done_d),
         .pop   (grant[ch]),
         .dout  (head[ch]),
         .empty (empty[ch]),
         .ovf   (buf_ovf[ch])
      );
   end

   assign avail = ~empty;

   wb_rr_scan #(.N(NUM_CH), .C(COMMIT_W), .CH_W(CH_W)) scan_i (
      .start      (ptr_q),
      .avail      (avail),
      .grant      (grant),
      .slot_v     (slot_v),
      .slot_ch    (slot_ch),
      .next_start (ptr_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q <= '0;
      else        ptr_q <= ptr_d;
   end

   for (genvar c = 0; c < COMMIT_W; c++) begin : g_slot
      logic [EW-1:0] sel;
      assign sel                          = slot_v[c] ? head[slot_ch[c]] : '0;
      assign wb_valid[c]                  = slot_v[c];
      assign wb_chan[c*CH_W +: CH_W]      = slot_v[c] ? slot_ch[c] : '0;
      assign wb_tag[c*TAG_W +: TAG_W]     = sel[EW-1 -: TAG_W];
      assign wb_data[c*DATA_W +: DATA_W]  = sel[DATA_W-1:0];

      if (c > 0) begin : g_pack
         // R6: slots fill from slot 0 upward
         assert_packed_R6: assert property (@(posedge clk) disable iff (!rst_n)
            wb_valid[c] |-> wb_valid[c-1]);
      end
      for (genvar o = 0; o < c; o++) begin : g_uniq
         // R5: one entry per buffer per cycle
         assert_distinct_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wb_valid[c] && wb_valid[o]) |->
            (wb_chan[c*CH_W +: CH_W] != wb_chan[o*CH_W +: CH_W]));
      end
   end

   // R5: only non-empty buffers are granted
   assert_grant_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & empty) == '0);
   // R4: bus filled up to the smaller of capacity and demand
   assert_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(wb_valid) == (($countones(avail) < COMMIT_W) ?
                               $countones(avail) : COMMIT_W));
   // R9: capacity left over keeps the scan start in place
   assert_hold_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(avail) < COMMIT_W) |=> (ptr_q == $past(ptr_q)));
endmodule

// File: tb/wb_rr_arbiter_tb.sv
module wb_rr_arbiter_tb_top;
   localparam int N    = 4;
   localparam int C    = 2;
   localparam int D    = 4;
   localparam int BL   = 1;
   localparam int TW   = 6;
   localparam int DW   = 16;
   localparam int CHW  = 2;
   localparam int MAXL = BL + N - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [N-1:0]      iv = '0;
   logic [N*TW-1:0]   itag = '0;
   logic [N*DW-1:0]   idat = '0;
   logic [C-1:0]      wb_valid;
   logic [C*CHW-1:0]  wb_chan;
   logic [C*TW-1:0]   wb_tag;
   logic [C*DW-1:0]   wb_data;
   logic [N-1:0]      buf_ovf;

   always #10 clk = ~clk;

   wb_rr_arbiter #(.NUM_CH(N), .COMMIT_W(C), .BUF_DEPTH(D), .BASE_LAT(BL),
                   .TAG_W(TW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .iss_valid(iv), .iss_tag(itag), .iss_data(idat),
      .wb_valid(wb_valid), .wb_chan(wb_chan), .wb_tag(wb_tag), .wb_data(wb_data),
      .buf_ovf(buf_ovf));

   // reference state built from the requirements
   logic          pv  [N][MAXL];
   logic [TW-1:0] ptg [N][MAXL];
   logic [DW-1:0] pdt [N][MAXL];
   logic [TW-1:0] qt  [N][D];
   logic [DW-1:0] qd  [N][D];
   int            qc  [N];
   logic [N-1:0]  movf;
   int            mptr;
   int            serial;
   int            checks = 0;
   int            errors = 0;
   logic [C-1:0]  obs_v;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int ch = 0; ch < N; ch++) begin
         qc[ch] = 0;
         for (int s = 0; s < MAXL; s++) begin
            pv[ch][s] = 1'b0; ptg[ch][s] = '0; pdt[ch][s] = '0;
         end
      end
      movf = '0;
      mptr = 0;
   endtask

   // one cycle: compare at the falling edge, then drive the next inputs
   task automatic step(input logic [N-1:0] v, input string req);
      int used, visits, idx, lat;
      logic [N-1:0] gr;
      int ech [C];
      bit ev  [C];
      @(negedge clk);
      obs_v  = wb_valid;
      used   = 0;
      visits = N;
      gr     = '0;
      for (int c = 0; c < C; c++) begin ev[c] = 1'b0; ech[c] = 0; end
      for (int k = 0; k < N; k++) begin
         idx = (mptr + k) % N;
         if (used < C && qc[idx] > 0) begin
            gr[idx] = 1'b1; ev[used] = 1'b1; ech[used] = idx; used++;
            if (used == C) visits = k + 1;
         end
      end
      for (int c = 0; c < C; c++) begin
         check(wb_valid[c] == ev[c], req, "slot valid", longint'(wb_valid[c]), longint'(ev[c]));
         if (ev[c] && wb_valid[c]) begin
            check(int'(wb_chan[c*CHW +: CHW]) == ech[c], req, "slot chan",
                  longint'(wb_chan[c*CHW +: CHW]), longint'(ech[c]));
            check(wb_tag[c*TW +: TW] == qt[ech[c]][0], req, "slot tag",
                  longint'(wb_tag[c*TW +: TW]), longint'(qt[ech[c]][0]));
            check(wb_data[c*DW +: DW] == qd[ech[c]][0], req, "slot data",
                  longint'(wb_data[c*DW +: DW]), longint'(qd[ech[c]][0]));
         end
      end
      check(buf_ovf == movf, req, "ovf flags", longint'(buf_ovf), longint'(movf));
      // advance the reference over the coming edge
      for (int ch = 0; ch < N; ch++) begin
         lat = BL + ch;
         if (gr[ch]) begin
            for (int s = 0; s < D - 1; s++) begin qt[ch][s] = qt[ch][s+1]; qd[ch][s] = qd[ch][s+1]; end
            qc[ch]--;
         end
         if (pv[ch][lat-1]) begin
            if (qc[ch] == D) movf[ch] = 1'b1;
            else begin qt[ch][qc[ch]] = ptg[ch][lat-1]; qd[ch][qc[ch]] = pdt[ch][lat-1]; qc[ch]++; end
         end
         for (int s = lat - 1; s > 0; s--) begin
            pv[ch][s] = pv[ch][s-1]; ptg[ch][s] = ptg[ch][s-1]; pdt[ch][s] = pdt[ch][s-1];
         end
         iv[ch]                = v[ch];
         itag[ch*TW +: TW]     = TW'(serial);
         idat[ch*DW +: DW]     = DW'(serial * 37 + ch * 5 + 3);
         pv[ch][0]             = v[ch];
         ptg[ch][0]            = TW'(serial);
         pdt[ch][0]            = DW'(serial * 37 + ch * 5 + 3);
         serial++;
      end
      mptr = (mptr + visits) % N;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      iv    = '0;
      repeat (3) @(negedge clk);
      model_clear();
      rst_n = 1'b1;
   endtask

   task automatic t_reset(input string req);
      do_reset();
      check(wb_valid == '0, req, "valid after reset", longint'(wb_valid), 0);
      check(buf_ovf == '0, req, "ovf after reset", longint'(buf_ovf), 0);
   endtask

   // R1: fixed latency per channel
   task automatic t_latency();
      int found;
      for (int ch = 0; ch < N; ch++) begin
         step(N'(1) << ch, "R1");
         found = 0;
         for (int k = 1; k <= 8; k++) begin
            step('0, "R1");
            if (found == 0 && obs_v[0]) found = k;
         end
         check(found == BL + ch + 1, "R1", "latency steps", longint'(found), longint'(BL + ch + 1));
      end
   endtask

   // R2: one channel streaming every cycle keeps order
   task automatic t_stream();
      for (int k = 0; k < 8; k++) step(4'b0001, "R2");
      for (int k = 0; k < 6; k++) step('0, "R2");
   endtask

   // R4: two channels concurrently at bus capacity
   task automatic t_pair();
      for (int k = 0; k < 8; k++) step(4'b0011, "R4");
      for (int k = 0; k < 6; k++) step('0, "R4");
   endtask

   // R7 R8: backlog on every buffer drains in rotating order
   task automatic t_rotate();
      for (int k = 0; k < 2; k++) step(4'b1111, "R7 R8");
      for (int k = 0; k < 10; k++) step('0, "R7 R8");
      for (int k = 0; k < 3; k++) step(4'b1010, "R7 R8");
      for (int k = 0; k < 8; k++) step('0, "R7 R8");
   endtask

   // R9: a single busy buffer leaves capacity unused
   task automatic t_partial();
      for (int k = 0; k < 6; k++) step(4'b0100, "R9");
      for (int k = 0; k < 3; k++) step(4'b0110, "R9");
      for (int k = 0; k < 8; k++) step('0, "R9");
      check(buf_ovf == '0, "R3", "no overflow at fitting load", longint'(buf_ovf), 0);
   endtask

   // R3: saturate all channels; simultaneous arrival and departure on full buffers
   task automatic t_overflow();
      for (int k = 0; k < 16; k++) step(4'b1111, "R3");
      for (int k = 0; k < 12; k++) step('0, "R3");
      check(buf_ovf != '0, "R3", "overflow raised", longint'(buf_ovf), longint'(movf));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      serial = 1;
      model_clear();
      t_reset("R10");
      t_latency();
      t_stream();
      t_pair();
      t_rotate();
      t_partial();
      t_overflow();
      t_reset("R10");
      for (int k = 0; k < 4; k++) step('0, "R10");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule